// File: doc/BRIEF.md
# Grouped Random Flip-Mask Generator

This block produces a wide bit-flip mask for noise injection. The mask is split into equal groups of 64 bits. Each group draws a 14-bit field from a 128-bit pseudo-random word. Six bits of that field choose a bit position inside the group, and eight bits form a sample. The group gets a single set bit at the chosen position when the sample is below a threshold. The threshold is derived at elaboration from a rate fraction NUM/DEN. All other mask bits are zero, so each group holds at most one flipped bit.

The random word is the state of an xorshift generator with four 32-bit words. The generator steps only while its advance input is high. A consumer asks for a new mask with a load strobe, which captures the mask of the current random word into an output register. A clear strobe zeroes that register and wins over load. Elaboration stops when the group width is not 64, when the random fields do not fit in 128 bits, when the rate fraction is out of range, or when the seed is zero.

Top module: `flipmask_gen`

## Requirements
- R1: After reset the mask output is all zero and the generator state is {SEED, SEED}, with SEED in the upper 64 bits.
- R2: The state holds four 32-bit words: w0 = bits 31:0, w1 = 63:32, w2 = 95:64, w3 = 127:96. One step sets t = w0 ^ (w0 << 11), then w0' = w1, w1' = w2, w2' = w3 and w3' = w3 ^ (w3 >> 19) ^ t ^ (t >> 8). A step happens on a clock edge only when advEn is 1.
- R3: Group g takes its bit index from state bits [g*14 +: 6] and its sample from state bits [g*14+6 +: 8].
- R4: The threshold is (RATE_NUM*256)/RATE_DEN in integer arithmetic. Group g sets mask bit g*64 + index when the sample is strictly below the threshold, and sets no bit otherwise. Every group therefore has at most one set bit.
- R5: When loadMask is 1 and clearMask is 0 on an edge, the mask output shows, from the next cycle, the mask of the state as it was before that edge. This holds even when advEn is 1 on the same edge.
- R6: When clearMask is 1 on an edge, the mask output becomes zero whatever the value of loadMask.
- R7: When loadMask and clearMask are both 0, the mask output holds its value even while the generator advances.
- R8: With RATE_NUM = 0 every loaded mask is zero. With RATE_NUM = RATE_DEN every group of a loaded mask has exactly one set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| advEn | input | 1 | Step the random generator on this edge |
| loadMask | input | 1 | Capture the mask of the current random word |
| clearMask | input | 1 | Zero the mask register; takes priority over loadMask |
| flipMask | output | HASH_BITS | Registered flip mask |

## Verification
The hardest case to reach is a load on the same edge as a generator step. The mask must then come from the word before the step, and that difference only shows in the next load. The stimulus mixes advance, load and clear in a fixed pattern over hundreds of cycles, including loads without steps and steps without loads. A software model of the generator follows the same schedule. Two more instances at zero rate and at full rate share the same stimulus, so every loaded mask also checks both threshold extremes.

// File: rtl/flipmask_pkg.sv
package flipmask_pkg;
  localparam int GROUP_W     = 64;
  localparam int IDX_W       = 6;
  localparam int SAMPLE_W    = 8;
  localparam int FIELD_W     = IDX_W + SAMPLE_W;
  localparam int RNG_W       = 128;
  localparam int RNG_WORD_W  = 32;
  localparam int SAMPLE_SPAN = 2 ** SAMPLE_W;

  typedef struct packed {
    logic stepRng;
    logic captureMask;
    logic zeroMask;
  } ctrlStrobes_t;
endpackage

// File: rtl/flipmask_ctrl.sv
module flipmask_ctrl
  import flipmask_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advEn,
  input  logic         loadMask,
  input  logic         clearMask,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.stepRng     = advEn;
    strobes.zeroMask    = clearMask;
    strobes.captureMask = loadMask & ~clearMask;
  end

  // R6: clear and capture never fire together
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.zeroMask && strobes.captureMask));
endmodule

// File: rtl/flipmask_prng.sv
module flipmask_prng
  import flipmask_pkg::*;
#(
  parameter logic [63:0] SEED = 64'hB504_F32D_B504_F32D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stepRng,
  output logic [RNG_W-1:0] rngState
);
  logic [RNG_WORD_W-1:0] w0, w1, w2, w3, tmix, wNew;

  always_comb begin
    w0   = rngState[0*RNG_WORD_W +: RNG_WORD_W];
    w1   = rngState[1*RNG_WORD_W +: RNG_WORD_W];
    w2   = rngState[2*RNG_WORD_W +: RNG_WORD_W];
    w3   = rngState[3*RNG_WORD_W +: RNG_WORD_W];
    tmix = w0 ^ (w0 << 11);
    wNew = w3 ^ (w3 >> 19) ^ tmix ^ (tmix >> 8);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rngState <= {SEED, SEED};
    else if (stepRng) rngState <= {wNew, w3, w2, w1};
  end

  // R2: generator holds when not stepped
  a_r2_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    !stepRng |=> $stable(rngState));
  // R2: word shift on a step
  a_r2_word_shift: assert property (@(posedge clk) disable iff (!rst_n)
    stepRng |=> rngState[RNG_WORD_W-1:0] == $past(rngState[2*RNG_WORD_W-1:RNG_WORD_W]));
  // R2: a nonzero state stays nonzero
  a_r2_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    rngState != '0);
endmodule

// File: rtl/flipmask_groups.sv
module flipmask_groups
  import flipmask_pkg::*;
#(
  parameter int HASH_BITS  = 512,
  parameter int NOISE_BITS = 8,
  parameter int THRESH     = 179,
  localparam int USED_W    = NOISE_BITS * FIELD_W
) (
  input  logic [USED_W-1:0]    rndUsed,
  output logic [HASH_BITS-1:0] maskNext
);
  localparam logic [SAMPLE_W:0] THRESH_V = (SAMPLE_W+1)'(THRESH);

  for (genvar g = 0; g < NOISE_BITS; g++) begin : gGroup
    logic [IDX_W-1:0]    bitIdx;
    logic [SAMPLE_W-1:0] sample;
    logic                hit;
    assign bitIdx = rndUsed[g*FIELD_W +: IDX_W];
    assign sample = rndUsed[g*FIELD_W + IDX_W +: SAMPLE_W];
    assign hit    = {1'b0, sample} < THRESH_V;
    assign maskNext[g*GROUP_W +: GROUP_W] =
      hit ? (GROUP_W'(1) << bitIdx) : '0;
  end
endmodule

// File: rtl/flipmask_datapath.sv
module flipmask_datapath
  import flipmask_pkg::*;
#(
  parameter int          HASH_BITS  = 512,
  parameter int          NOISE_BITS = 8,
  parameter int          RATE_NUM   = 70,
  parameter int          RATE_DEN   = 100,
  parameter logic [63:0] SEED       = 64'hB504_F32D_B504_F32D
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrobes_t         strobes,
  output logic [HASH_BITS-1:0] flipMask
);
  localparam int USED_W = NOISE_BITS * FIELD_W;
  localparam int THRESH = (RATE_NUM * SAMPLE_SPAN) / RATE_DEN;

  initial begin
    if (NOISE_BITS <= 0 || HASH_BITS % NOISE_BITS != 0)
      $fatal(1, "mask width must split evenly into groups");
    if (HASH_BITS / NOISE_BITS != GROUP_W)
      $fatal(1, "group width must be %0d", GROUP_W);
    if (USED_W > RNG_W)
      $fatal(1, "random fields exceed %0d bits", RNG_W);
    if (RATE_DEN <= 0 || RATE_NUM < 0 || RATE_NUM > RATE_DEN)
      $fatal(1, "rate fraction out of range");
    if (SEED == 64'd0)
      $fatal(1, "seed must be nonzero");
  end

  logic [RNG_W-1:0]     rngState;
  logic [HASH_BITS-1:0] maskNext;

  flipmask_prng #(.SEED(SEED)) u_prng (
    .clk      (clk),
    .rst_n    (rst_n),
    .stepRng  (strobes.stepRng),
    .rngState (rngState)
  );

  flipmask_groups #(
    .HASH_BITS  (HASH_BITS),
    .NOISE_BITS (NOISE_BITS),
    .THRESH     (THRESH)
  ) u_groups (
    .rndUsed  (rngState[USED_W-1:0]),
    .maskNext (maskNext)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   flipMask <= '0;
    else if (strobes.zeroMask)    flipMask <= '0;
    else if (strobes.captureMask) flipMask <= maskNext;
  end

  // R6: clear empties the register
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.zeroMask |=> flipMask == '0);
  // R7: no strobe, no change
  a_r7_hold_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.zeroMask && !strobes.captureMask |=> $stable(flipMask));
  // R5: capture takes the mask of the pre-step word
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.captureMask |=> flipMask == $past(maskNext));

  for (genvar g = 0; g < NOISE_BITS; g++) begin : gChk
    // R4: at most one flipped bit per group
    a_r4_one_per_group: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(flipMask[g*GROUP_W +: GROUP_W]) <= 1);
    if (THRESH >= SAMPLE_SPAN) begin : gFull
      // R8: full rate flips exactly one bit per group
      a_r8_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        strobes.captureMask |=> $countones(flipMask[g*GROUP_W +: GROUP_W]) == 1);
    end
    if (THRESH == 0) begin : gZero
      // R8: zero rate never flips
      a_r8_zero_rate: assert property (@(posedge clk) disable iff (!rst_n)
        flipMask[g*GROUP_W +: GROUP_W] == '0);
    end
  end
endmodule

// File: rtl/flipmask_gen.sv
module flipmask_gen
  import flipmask_pkg::*;
#(
  parameter int          HASH_BITS  = 512,
  parameter int          NOISE_BITS = 8,
  parameter int          RATE_NUM   = 70,
  parameter int          RATE_DEN   = 100,
  parameter logic [63:0] SEED       = 64'hB504_F32D_B504_F32D
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 advEn,
  input  logic                 loadMask,
  input  logic                 clearMask,
  output logic [HASH_BITS-1:0] flipMask
);
  ctrlStrobes_t strobes;

  flipmask_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .advEn     (advEn),
    .loadMask  (loadMask),
    .clearMask (clearMask),
    .strobes   (strobes)
  );

  flipmask_datapath #(
    .HASH_BITS  (HASH_BITS),
    .NOISE_BITS (NOISE_BITS),
    .RATE_NUM   (RATE_NUM),
    .RATE_DEN   (RATE_DEN),
    .SEED       (SEED)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .flipMask (flipMask)
  );
endmodule

// File: tb/flipmask_gen_tb.sv
`timescale 1ns/1ps
module flipmask_gen_tb;
  localparam int HB = 512;
  localparam int NB = 8;
  localparam logic [63:0] SEED = 64'hB504_F32D_B504_F32D;
  localparam int THR_MAIN = (70 * 256) / 100;

  logic clk = 0;
  logic rst_n = 0;
  logic advEn = 0, loadMask = 0, clearMask = 0;
  logic [HB-1:0] flipMask, maskZero, maskFull;

  int total = 0;
  int bad = 0;
  logic [127:0] mState;
  logic [HB-1:0] expMain, expZero, expFull;

  always #2 clk = ~clk;

  flipmask_gen #(.RATE_NUM(70), .RATE_DEN(100), .SEED(SEED)) u_dut (
    .clk(clk), .rst_n(rst_n), .advEn(advEn), .loadMask(loadMask),
    .clearMask(clearMask), .flipMask(flipMask));
  flipmask_gen #(.RATE_NUM(0), .RATE_DEN(100), .SEED(SEED)) u_dutZero (
    .clk(clk), .rst_n(rst_n), .advEn(advEn), .loadMask(loadMask),
    .clearMask(clearMask), .flipMask(maskZero));
  flipmask_gen #(.RATE_NUM(100), .RATE_DEN(100), .SEED(SEED)) u_dutFull (
    .clk(clk), .rst_n(rst_n), .advEn(advEn), .loadMask(loadMask),
    .clearMask(clearMask), .flipMask(maskFull));

  function automatic logic [127:0] stepModel(input logic [127:0] s);
    logic [31:0] a, b, c, d, t;
    a = s[31:0]; b = s[63:32]; c = s[95:64]; d = s[127:96];
    t = a ^ (a << 11);
    return {d ^ (d >> 19) ^ t ^ (t >> 8), d, c, b};
  endfunction

  function automatic logic [HB-1:0] maskModel(input logic [127:0] s, input int thr);
    logic [HB-1:0] m = '0;
    for (int g = 0; g < NB; g++) begin
      int idx = int'(s[g*14 +: 6]);
      int smp = int'(s[g*14 + 6 +: 8]);
      if (smp < thr) m[g*64 + idx] = 1'b1;
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [HB-1:0] act, input logic [HB-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic checkGroups(input string req, input logic [HB-1:0] m, input int lo, input int hi);
    for (int g = 0; g < NB; g++) begin
      int c = $countones(m[g*64 +: 64]);
      total++;
      if (c < lo || c > hi) begin
        bad++;
        $display("FAIL %s group=%0d act=%0d exp=%0d..%0d", req, g, c, lo, hi);
      end
    end
  endtask

  // one clock with the given strobes, then compare against the model
  task automatic cycle(input logic adv, input logic ld, input logic clr);
    @(negedge clk);
    advEn = adv; loadMask = ld; clearMask = clr;
    if (clr) begin
      expMain = '0; expZero = '0; expFull = '0;
    end else if (ld) begin
      expMain = maskModel(mState, THR_MAIN);
      expZero = '0;
      expFull = maskModel(mState, 256);
    end
    if (adv) mState = stepModel(mState);
    @(posedge clk); #1;
    check(clr ? "R6" : (ld ? "R5" : "R7"), flipMask, expMain);
    check("R8 zero", maskZero, expZero);
    check("R8 full", maskFull, expFull);
    checkGroups("R4", flipMask, 0, 1);
    if (ld && !clr) checkGroups("R8 full", maskFull, 1, 1);
  endtask

  task automatic testReset();
    #1;
    check("R1", flipMask, '0);
    mState = {SEED, SEED};
    expMain = '0; expZero = '0; expFull = '0;
    @(negedge clk); rst_n = 1;
    cycle(0, 1, 0); // R1: seed word is the first mask source
  endtask

  task automatic testLoadNoStep();
    cycle(0, 1, 0); // R5: same word twice
    cycle(0, 1, 0);
  endtask

  task automatic testLoadWithStep();
    cycle(1, 1, 0); // R5: pre-step word used
    cycle(0, 1, 0); // R2: post-step word now visible
  endtask

  task automatic testHold();
    cycle(1, 0, 0); // R7: mask holds while R2 stepping
    cycle(1, 0, 0);
    cycle(0, 0, 0);
    cycle(0, 1, 0); // R3/R4: layout after two steps
  endtask

  task automatic testClear();
    cycle(0, 1, 0);
    cycle(0, 1, 1); // R6: clear beats load
    cycle(1, 0, 1);
    cycle(0, 1, 0);
    cycle(0, 0, 1);
  endtask

  task automatic testLongRun();
    for (int k = 0; k < 300; k++) begin
      cycle(k % 3 != 1, (k % 2 == 0) || (k % 7 == 3), k % 11 == 5); // R2 R3 R4
    end
  endtask

  initial begin
    fork
      begin
        testReset();
        testLoadNoStep();
        testLoadWithStep();
        testHold();
        testClear();
        testLongRun();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule